// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Errors and Receive Timeout

This block receives asynchronous serial characters on a single line input. A bit-rate enable runs at sixteen times the bit rate. The line is first passed through a synchronizer, and a three-sample majority vote then settles the value of each bit near its centre. Each character has 5 to 8 data bits, sent least significant bit first. An optional parity bit and one stop bit follow the data. A completed character is placed right-aligned in a holding register, and a ready flag tells the host that it can be read. The host clears the ready flag with a read strobe.

Four line faults raise error flags: parity mismatch, a low stop bit (framing), a character that arrives while the previous one is still unread (overrun), and a frame that is low from start to stop (break). Each flag stays set until the host issues a status-clear command. A separate inactivity timer is armed by a command and counts in whole bit periods. It raises a timeout flag if no character completes within the programmed count. Command strobes enable, disable and reset the receiver.

The frame controller has seven states:
- OFF: the receiver is disabled.
- WAIT_HI: the controller waits for the line to return high.
- IDLE: the controller watches for a falling start edge.
- START: the start bit is validated.
- DATA: data bits are collected.
- PAR: the parity bit is sampled.
- STOP: the stop bit is judged.

The transitions are:
- OFF to WAIT_HI on enable.
- WAIT_HI to IDLE when the vote reads high.
- IDLE to START when the line reads low.
- START back to IDLE if the mid-bit vote is high (a false start).
- START to DATA at the end of the bit.
- DATA to PAR or STOP after the last data bit.
- PAR to STOP.
- STOP to IDLE on a high stop sample, or to WAIT_HI on a low one.
- Any state to OFF on disable.
- Any enabled state to WAIT_HI on a receiver reset.

Top module: `serial_rx_core`

## Requirements
- R1: A frame is one low start bit, then 5+`cfg_len` data bits (`cfg_len` values 0 to 3 give 5 to 8 bits), least significant bit first, then an optional parity bit and one stop bit. Each bit lasts 16 `baud_tick` pulses. After the stop bit is sampled, the character appears right-aligned on `rx_data` with its upper bits zero, and `rx_ready` is set. After reset, `rx_ready` and all flags are 0.
- R2: `cfg_par` selects the parity bit as follows: 0 means even (data ones plus parity bit is even), 1 means odd, 2 means the bit is always 0, and 3 means the bit is always 1. The values 4, 6 and 7 mean there is no parity bit. A received parity bit that violates the selected rule sets `err_par`.
- R3: With `cfg_par` = 5, the parity slot carries an address marker. It is copied to `rx_addr` with the character and never sets `err_par`.
- R4: A low stop bit on a frame that is not all low sets `err_frame`. The character is still delivered.
- R5: A frame whose start bit, data bits, parity bit (if present) and stop bit are all low sets `brk_rcvd`. It delivers no character and does not set `err_frame`. Reception resumes once the line returns high.
- R6: A character that completes while `rx_ready` is still set sets `err_ovr`, and the new character replaces the held one.
- R7: `err_par`, `err_frame`, `err_ovr` and `brk_rcvd` stay set until `cmd_rst_sta`. If an error is detected in the same cycle as `cmd_rst_sta`, the flag stays set.
- R8: `rd_strobe` clears `rx_ready`. A read in the same cycle as a character completion consumes the old character: `rx_ready` stays set and no overrun is flagged.
- R9: `cmd_rx_en` enables the receiver and `cmd_rx_dis` disables it, with disable winning if both are given together. While disabled, line activity delivers nothing.
- R10: `cmd_rx_rst` discards any partial character and clears `rx_ready`. It does not change the enable state or the sticky flags.
- R11: `cmd_start_to` clears `to_flag` and loads `cfg_timeout` bit periods. `to_flag` is set when the count elapses. A character that completes while the timer is armed reloads the count.
- R12: If `cfg_timeout` is 0 when `cmd_start_to` is given, the timer is left disarmed and `to_flag` stays clear.
- R13: A low pulse on the line shorter than a quarter of a bit is rejected by the mid-start-bit majority vote and delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cmd_rx_en | input | 1 | Enable receiver strobe |
| cmd_rx_dis | input | 1 | Disable receiver strobe |
| cmd_rx_rst | input | 1 | Receiver reset strobe |
| cmd_rst_sta | input | 1 | Clear sticky error flags strobe |
| cmd_start_to | input | 1 | Restart timeout strobe |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par | input | 3 | Parity mode |
| cfg_timeout | input | TO_W | Timeout in bit periods, 0 disables |
| rd_strobe | input | 1 | Host read of the holding register |
| rx_data | output | CHAR_W | Held character |
| rx_addr | output | 1 | Address marker of the held character |
| rx_ready | output | 1 | Unread character present |
| err_par | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun error |
| brk_rcvd | output | 1 | Sticky break received |
| to_flag | output | 1 | Timeout elapsed |

## Verification
Two pairs of events can land on the same clock edge. A character can complete in the same cycle as a host read, and a parity error can be detected in the same cycle as a status-clear command. The bench first sends one calibration frame and counts the clocks from its start bit to the rise of `rx_ready`. It then replays identical frames and pulses `rd_strobe` or `cmd_rst_sta` so that the pulse lands exactly on that completion edge. The outcome is judged at the ports: `rx_ready` must stay high with `err_ovr` clear and the new data held, and `err_par` must read set after the clear command.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT_HI,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    localparam logic [2:0] PM_EVEN  = 3'd0;
    localparam logic [2:0] PM_ODD   = 3'd1;
    localparam logic [2:0] PM_SPACE = 3'd2;
    localparam logic [2:0] PM_MARK  = 3'd3;
    localparam logic [2:0] PM_ADDR  = 3'd5;

    function automatic logic par_slot_used(input logic [2:0] mode);
        return (mode <= PM_MARK) || (mode == PM_ADDR);
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTES       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    output logic line_o,
    output logic vote_o
);
    localparam int HALF = VOTES / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTES-1:0]       hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            if (tick) hist_q <= {hist_q[VOTES-2:0], line_o};
        end
    end

    assign line_o = sync_q[SYNC_STAGES-1];
    assign vote_o = ($countones(hist_q) > HALF);

endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_i,
    input  logic              vote_i,
    input  logic              enable_i,
    input  logic              flush_i,
    input  logic [1:0]        cfg_len_i,
    input  logic [2:0]        cfg_par_i,
    output logic              done_o,
    output logic              brk_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              addr_o
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam int NW  = $clog2(CHAR_W + 1);

    rx_state_t         st_q, st_d;
    logic [CW-1:0]     cnt_q;
    logic [NW-1:0]     idx_q;
    logic [CHAR_W-1:0] sh_q;
    logic              pbit_q;

    logic              at_mid, at_last, use_par, is_brk, par_bad;
    logic [NW-1:0]     nbits, shamt;
    logic [CHAR_W-1:0] aligned;

    assign at_mid  = tick && (cnt_q == CW'(MID));
    assign at_last = tick && (cnt_q == CW'(OVS - 1));
    assign use_par = par_slot_used(cfg_par_i);
    assign nbits   = NW'(CHAR_W - 3) + NW'(cfg_len_i);
    assign shamt   = NW'(CHAR_W) - nbits;
    assign aligned = sh_q >> shamt;
    assign is_brk  = !vote_i && (aligned == '0) && (!use_par || !pbit_q);

    always_comb begin
        unique case (cfg_par_i)
            PM_EVEN:  par_bad = (^aligned) ^ pbit_q;
            PM_ODD:   par_bad = !((^aligned) ^ pbit_q);
            PM_SPACE: par_bad = pbit_q;
            PM_MARK:  par_bad = !pbit_q;
            default:  par_bad = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:     if (enable_i) st_d = ST_WAIT_HI;
            ST_WAIT_HI: if (tick && vote_i) st_d = ST_IDLE;
            ST_IDLE:    if (tick && !line_i) st_d = ST_START;
            ST_START: begin
                if (at_mid && vote_i) st_d = ST_IDLE;
                else if (at_last)     st_d = ST_DATA;
            end
            ST_DATA:    if (at_last && (idx_q == nbits - 1'b1))
                            st_d = use_par ? ST_PAR : ST_STOP;
            ST_PAR:     if (at_last) st_d = ST_STOP;
            ST_STOP:    if (at_mid) st_d = vote_i ? ST_IDLE : ST_WAIT_HI;
            default:    st_d = ST_OFF;
        endcase
        if (!enable_i)    st_d = ST_OFF;
        else if (flush_i) st_d = ST_WAIT_HI;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            pbit_q <= 1'b0;
            done_o <= 1'b0;
            brk_o  <= 1'b0;
            data_o <= '0;
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            addr_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            brk_o  <= 1'b0;
            if ((st_d != st_q) || at_last) cnt_q <= '0;
            else if (tick)                 cnt_q <= cnt_q + 1'b1;
            if (st_q == ST_START)                idx_q <= '0;
            else if (st_q == ST_DATA && at_last) idx_q <= idx_q + 1'b1;
            if (st_q == ST_DATA && at_mid) sh_q <= {vote_i, sh_q[CHAR_W-1:1]};
            if (st_q == ST_PAR && at_mid)  pbit_q <= vote_i;
            if (st_q == ST_STOP && at_mid && enable_i && !flush_i) begin
                done_o <= !is_brk;
                brk_o  <= is_brk;
                data_o <= aligned;
                perr_o <= par_bad;
                ferr_o <= !vote_i;
                addr_o <= (cfg_par_i == PM_ADDR) && pbit_q;
            end
        end
    end

    // R1
    done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(st_q) == ST_STOP));

    // R9
    disable_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (st_q == ST_OFF));

endmodule

// File: rtl/srx_timeout.sv
module srx_timeout #(
    parameter int OVS  = 16,
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            start_i,
    input  logic            char_done_i,
    input  logic [TO_W-1:0] cfg_to_i,
    output logic            flag_o
);
    localparam int CW = $clog2(OVS);

    logic [CW-1:0]   div_q;
    logic [TO_W-1:0] cnt_q;
    logic            armed_q;
    logic            load;

    assign load = start_i || (char_done_i && armed_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            flag_o  <= 1'b0;
        end else begin
            if (start_i) flag_o <= 1'b0;
            if (load && (cfg_to_i != '0)) begin
                armed_q <= 1'b1;
                cnt_q   <= cfg_to_i;
                div_q   <= '0;
            end else if (start_i) begin
                armed_q <= 1'b0;
            end else if (armed_q && tick) begin
                if (div_q == CW'(OVS - 1)) begin
                    div_q <= '0;
                    if (cnt_q == TO_W'(1)) begin
                        armed_q <= 1'b0;
                        flag_o  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    // R12
    zero_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (cfg_to_i == '0)) |=> !flag_o);

    // R11
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !flag_o);

    // R11
    flag_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(armed_q));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int OVS         = 16,
    parameter int CHAR_W      = 8,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              cmd_rx_en,
    input  logic              cmd_rx_dis,
    input  logic              cmd_rx_rst,
    input  logic              cmd_rst_sta,
    input  logic              cmd_start_to,
    input  logic [1:0]        cfg_len,
    input  logic [2:0]        cfg_par,
    input  logic [TO_W-1:0]   cfg_timeout,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_addr,
    output logic              rx_ready,
    output logic              err_par,
    output logic              err_frame,
    output logic              err_ovr,
    output logic              brk_rcvd,
    output logic              to_flag
);
    logic              enabled_q;
    logic              line_s, vote_s;
    logic              fr_done, fr_brk, fr_perr, fr_ferr, fr_addr;
    logic [CHAR_W-1:0] fr_data;
    logic              accept;

    srx_sampler #(.SYNC_STAGES(SYNC_STAGES), .VOTES(3)) u_sampler (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
        .line_o(line_s), .vote_o(vote_s)
    );

    srx_frame #(.OVS(OVS), .CHAR_W(CHAR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick),
        .line_i(line_s), .vote_i(vote_s),
        .enable_i(enabled_q), .flush_i(cmd_rx_rst),
        .cfg_len_i(cfg_len), .cfg_par_i(cfg_par),
        .done_o(fr_done), .brk_o(fr_brk), .data_o(fr_data),
        .perr_o(fr_perr), .ferr_o(fr_ferr), .addr_o(fr_addr)
    );

    srx_timeout #(.OVS(OVS), .TO_W(TO_W)) u_timeout (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick),
        .start_i(cmd_start_to), .char_done_i(fr_done),
        .cfg_to_i(cfg_timeout), .flag_o(to_flag)
    );

    assign accept = fr_done && !cmd_rx_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enabled_q <= 1'b0;
            rx_ready  <= 1'b0;
            rx_data   <= '0;
            rx_addr   <= 1'b0;
            err_par   <= 1'b0;
            err_frame <= 1'b0;
            err_ovr   <= 1'b0;
            brk_rcvd  <= 1'b0;
        end else begin
            if (cmd_rx_dis)     enabled_q <= 1'b0;
            else if (cmd_rx_en) enabled_q <= 1'b1;

            if (cmd_rx_rst)     rx_ready <= 1'b0;
            else if (fr_done)   rx_ready <= 1'b1;
            else if (rd_strobe) rx_ready <= 1'b0;

            if (accept) begin
                rx_data <= fr_data;
                rx_addr <= fr_addr;
            end

            if (accept && fr_perr)                      err_par <= 1'b1;
            else if (cmd_rst_sta)                       err_par <= 1'b0;
            if (accept && fr_ferr)                      err_frame <= 1'b1;
            else if (cmd_rst_sta)                       err_frame <= 1'b0;
            if (accept && rx_ready && !rd_strobe)       err_ovr <= 1'b1;
            else if (cmd_rst_sta)                       err_ovr <= 1'b0;
            if (fr_brk && !cmd_rx_rst)                  brk_rcvd <= 1'b1;
            else if (cmd_rst_sta)                       brk_rcvd <= 1'b0;
        end
    end

    // R1
    ready_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(fr_done));

    // R6
    ovr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> $past(rx_ready));

    // R7
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_par) |-> $past(cmd_rst_sta));

    // R7
    frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_frame) |-> $past(cmd_rst_sta));

    // R5
    brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_rcvd) |-> $past(cmd_rst_sta));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !fr_done) |=> !rx_ready);

    // R10
    rst_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_rst |=> !rx_ready);

endmodule

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;

    localparam int C_EN = 0, C_DIS = 1, C_RST = 2, C_STA = 3, C_TO = 4, C_RD = 5;

    // {len[25:24], mode[23:21], data[20:13], flag[12], stop_low[11],
    //  exp_data[10:3], exp_perr[2], exp_ferr[1], exp_addr[0]}
    localparam logic [25:0] VEC [0:8] = '{
        {2'd3, 3'd0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0},
        {2'd3, 3'd1, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0},
        {2'd2, 3'd0, 8'h7F, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0, 1'b0},
        {2'd0, 3'd4, 8'h15, 1'b0, 1'b0, 8'h15, 1'b0, 1'b0, 1'b0},
        {2'd1, 3'd3, 8'h2A, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 1'b0},
        {2'd3, 3'd2, 8'h81, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0, 1'b0},
        {2'd3, 3'd5, 8'h42, 1'b1, 1'b0, 8'h42, 1'b0, 1'b0, 1'b1},
        {2'd3, 3'd4, 8'h5A, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0},
        {2'd0, 3'd1, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [5:0]  cmd = '0;
    logic [1:0]  cfg_len = 2'd3;
    logic [2:0]  cfg_par = 3'd4;
    logic [15:0] cfg_timeout = '0;
    logic [7:0]  rx_data;
    logic        rx_addr, rx_ready, err_par, err_frame, err_ovr, brk_rcvd, to_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int lat    = 0;

    always #2.5 clk = ~clk;

    serial_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .rxd(rxd),
        .cmd_rx_en(cmd[C_EN]), .cmd_rx_dis(cmd[C_DIS]), .cmd_rx_rst(cmd[C_RST]),
        .cmd_rst_sta(cmd[C_STA]), .cmd_start_to(cmd[C_TO]),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_timeout(cfg_timeout),
        .rd_strobe(cmd[C_RD]),
        .rx_data(rx_data), .rx_addr(rx_addr), .rx_ready(rx_ready),
        .err_par(err_par), .err_frame(err_frame), .err_ovr(err_ovr),
        .brk_rcvd(brk_rcvd), .to_flag(to_flag)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [5:0] m);
        cmd = m;
        clocks(1);
        cmd = '0;
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        clocks(16);
    endtask

    task automatic send_frame(input logic [1:0] len, input logic [2:0] mode,
                              input logic [7:0] d, input logic flag, input logic stop_low);
        int n;
        logic [7:0] m;
        logic p;
        n = 5 + int'(len);
        m = d & 8'((9'd1 << n) - 9'd1);
        case (mode)
            3'd0:    p = (^m) ^ flag;
            3'd1:    p = !(^m) ^ flag;
            3'd2:    p = flag;
            3'd3:    p = !flag;
            3'd5:    p = flag;
            default: p = 1'b0;
        endcase
        send_bit(1'b0);
        for (int i = 0; i < n; i++) send_bit(m[i]);
        if (mode <= 3'd3 || mode == 3'd5) send_bit(p);
        send_bit(!stop_low);
        rxd = 1'b1;
        clocks(32);
    endtask

    task automatic strobe_at(input int c, input int b);
        repeat (c - 1) @(posedge clk);
        #1;
        cmd[b] = 1'b1;
        @(posedge clk);
        #1;
        cmd[b] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        clocks(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset ready", rx_ready, 0);
        chk("R7 reset errors", {err_par, err_frame, err_ovr, brk_rcvd}, 0);
        chk("R11 reset timeout", to_flag, 0);
        clocks(1);
        pulse(6'b1 << C_EN);
        clocks(4);

        // table walk: R1 R2 R3 R4
        for (int k = 0; k <= 8; k++) begin
            pulse((6'b1 << C_RD) | (6'b1 << C_STA));
            cfg_len = VEC[k][25:24];
            cfg_par = VEC[k][23:21];
            send_frame(VEC[k][25:24], VEC[k][23:21], VEC[k][20:13], VEC[k][12], VEC[k][11]);
            @(negedge clk);
            chk($sformatf("R1 row %0d ready", k), rx_ready, 1);
            chk($sformatf("R1 row %0d data", k), rx_data, VEC[k][10:3]);
            chk($sformatf("R2 row %0d parity err", k), err_par, VEC[k][2]);
            chk($sformatf("R4 row %0d frame err", k), err_frame, VEC[k][1]);
            chk($sformatf("R3 row %0d addr", k), rx_addr, VEC[k][0]);
            clocks(1);
        end

        // R7 sticky parity across a good frame
        cfg_len = 2'd3; cfg_par = 3'd0;
        pulse((6'b1 << C_RD) | (6'b1 << C_STA));
        send_frame(2'd3, 3'd0, 8'h11, 1'b1, 1'b0);
        pulse(6'b1 << C_RD);
        send_frame(2'd3, 3'd0, 8'h22, 1'b0, 1'b0);
        @(negedge clk);
        chk("R7 parity stays set", err_par, 1);
        clocks(1);
        pulse(6'b1 << C_STA);
        @(negedge clk);
        chk("R7 status clear", err_par, 0);
        clocks(1);

        // R6 overrun, R8 read
        pulse(6'b1 << C_RD);
        send_frame(2'd3, 3'd0, 8'h31, 1'b0, 1'b0);
        send_frame(2'd3, 3'd0, 8'h32, 1'b0, 1'b0);
        @(negedge clk);
        chk("R6 overrun set", err_ovr, 1);
        chk("R6 newer data kept", rx_data, 8'h32);
        clocks(1);
        pulse(6'b1 << C_RD);
        @(negedge clk);
        chk("R8 read clears ready", rx_ready, 0);
        clocks(1);

        // R5 break
        pulse(6'b1 << C_STA);
        send_frame(2'd3, 3'd0, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        chk("R5 break flag", brk_rcvd, 1);
        chk("R5 no framing on break", err_frame, 0);
        chk("R5 no character on break", rx_ready, 0);
        clocks(1);
        pulse(6'b1 << C_STA);
        @(negedge clk);
        chk("R5 break cleared", brk_rcvd, 0);
        clocks(1);
        send_frame(2'd3, 3'd0, 8'h6E, 1'b0, 1'b0);
        @(negedge clk);
        chk("R5 resumes after break", rx_data, 8'h6E);
        clocks(1);

        // R13 short glitch
        pulse(6'b1 << C_RD);
        rxd = 1'b0;
        clocks(3);
        rxd = 1'b1;
        clocks(300);
        @(negedge clk);
        chk("R13 glitch rejected", rx_ready, 0);
        clocks(1);
        send_frame(2'd3, 3'd0, 8'h9D, 1'b0, 1'b0);
        @(negedge clk);
        chk("R13 frame after glitch", rx_data, 8'h9D);
        clocks(1);

        // R9 enable / disable
        pulse(6'b1 << C_RD);
        pulse((6'b1 << C_EN) | (6'b1 << C_DIS));
        send_frame(2'd3, 3'd0, 8'h44, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 disable wins, nothing received", rx_ready, 0);
        clocks(1);
        pulse(6'b1 << C_EN);
        clocks(4);
        send_frame(2'd3, 3'd0, 8'h45, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 re-enabled receives", rx_data, 8'h45);
        clocks(1);

        // R10 receiver reset
        pulse((6'b1 << C_RD) | (6'b1 << C_STA));
        send_frame(2'd3, 3'd0, 8'h50, 1'b1, 1'b0);
        pulse(6'b1 << C_RST);
        @(negedge clk);
        chk("R10 reset clears ready", rx_ready, 0);
        chk("R10 reset keeps error", err_par, 1);
        clocks(1);
        clocks(4);
        send_frame(2'd3, 3'd0, 8'h51, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10 enable kept after reset", rx_ready, 1);
        clocks(1);

        // R11 / R12 timeout
        cfg_timeout = 16'd4;
        pulse(6'b1 << C_TO);
        clocks(40);
        @(negedge clk);
        chk("R11 timeout not yet", to_flag, 0);
        clocks(40);
        @(negedge clk);
        chk("R11 timeout elapsed", to_flag, 1);
        clocks(1);
        pulse(6'b1 << C_TO);
        @(negedge clk);
        chk("R11 restart clears flag", to_flag, 0);
        clocks(1);
        cfg_timeout = 16'd0;
        pulse(6'b1 << C_TO);
        clocks(200);
        @(negedge clk);
        chk("R12 zero disables", to_flag, 0);
        clocks(1);
        cfg_timeout = 16'd20;
        pulse(6'b1 << C_TO);
        send_frame(2'd3, 3'd0, 8'h12, 1'b0, 1'b0);
        clocks(190);
        @(negedge clk);
        chk("R11 character reloads count", to_flag, 0);
        clocks(200);
        @(negedge clk);
        chk("R11 elapsed after reload", to_flag, 1);
        clocks(1);

        // calibration of completion edge
        pulse((6'b1 << C_RD) | (6'b1 << C_STA));
        fork
            send_frame(2'd3, 3'd0, 8'h70, 1'b0, 1'b0);
            begin
                lat = 0;
                while (1) begin
                    @(posedge clk);
                    lat++;
                    #1;
                    if (rx_ready) break;
                end
            end
        join
        // R8 read on completion edge (old character still unread)
        pulse(6'b1 << C_STA);
        fork
            send_frame(2'd3, 3'd0, 8'h71, 1'b0, 1'b0);
            strobe_at(lat, C_RD);
        join
        @(negedge clk);
        chk("R8 coincident read keeps ready", rx_ready, 1);
        chk("R8 coincident read no overrun", err_ovr, 0);
        chk("R8 coincident read new data", rx_data, 8'h71);
        clocks(1);
        // R7 status clear on the same edge as a parity error
        pulse((6'b1 << C_RD) | (6'b1 << C_STA));
        fork
            send_frame(2'd3, 3'd0, 8'h72, 1'b1, 1'b0);
            strobe_at(lat, C_STA);
        join
        @(negedge clk);
        chk("R7 new error beats clear", err_par, 1);
        clocks(1);

        report();
    end

endmodule